// File: doc/BRIEF.md
# Test Signal Generator with Accumulator

This block is a built-in stimulus source for a sample datapath. It drives an 18-bit in-phase (I) and an 18-bit quadrature (Q) sample output every clock. A small write-only register port picks one of four modes. The modes are off, DC/sawtooth, pseudo-random and external pass-through. The same port also loads a 16-bit start value and a 16-bit signed step.

In DC/sawtooth mode an 18-bit signed accumulator is loaded from the sign-extended start value. It then adds the sign-extended step on every clock and wraps on overflow. I carries the accumulator and Q carries the same word with its bit order mirrored. In pseudo-random mode a maximal-length shift register supplies the samples in the same I/Q arrangement. In external mode the external I/Q inputs pass straight through.

The block also keeps a sticky "check result available" flag with a mask bit that gates an interrupt line. A pulse from the downstream checker sets the flag, and software clears it with a register write.

Top module: `tsg_top`

## Requirements
- R1: After reset the mode is 00, start value, step and mask are zero, sig_i_o and sig_q_o are zero, and flag_o and irq_o are low.
- R2: Register writes use wr_addr_i: 0 = mode (wr_data_i[1:0]: 00 off, 01 DC/sawtooth, 10 pseudo-random, 11 external), 1 = start value, 2 = step, 3 = interrupt control. In mode 00 both sample outputs are zero whatever the external inputs are.
- R3: A write to address 1, or a mode write of 01 while the mode is not 01, loads the accumulator at that clock edge. The load value is the 16-bit start value with bits 17..15 all equal to start bit 15, and it appears on sig_i_o in the following cycle.
- R4: At every clock edge in mode 01 with no load, the accumulator adds the step sign-extended to 18 bits. A zero step holds a constant DC level. In other modes the accumulator holds its value.
- R5: Accumulator arithmetic wraps modulo 2^18 without saturating.
- R6: In modes 01 and 10, sig_q_o[k] equals sig_i_o[17-k] for every k.
- R7: Mode 10 outputs an 18-bit shift register state on sig_i_o. The state is seeded to 1 at reset and advances once per clock while the mode is 10, using new = {s[16:0], s[17]^s[10]}. It holds in all other modes.
- R8: In mode 11, sig_i_o equals ext_i_i and sig_q_o equals ext_q_i.
- R9: result_i high at a clock edge while the mode is not 00 sets flag_o. The flag stays set until a write to address 3 with wr_data_i[0]=1 clears it. A set and a clear in the same cycle leave the flag set. result_i has no effect in mode 00.
- R10: A write to address 3 stores wr_data_i[1] as the mask, and irq_o is high exactly when flag_o and the mask are both set.
- R11: A mode write of 01 while already in mode 01 does not reload the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 16 | Register write data |
| result_i | input | 1 | Pulse: check result available |
| ext_i_i | input | 18 | External I sample |
| ext_q_i | input | 18 | External Q sample |
| sig_i_o | output | 18 | I sample output |
| sig_q_o | output | 18 | Q sample output |
| flag_o | output | 1 | Sticky result-available flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
The embedded properties check every cycle that the mirrored Q matches I, that off mode gives zero and external mode passes through, and that each load leaves bits 17..15 equal. They also check that every accumulator update is exactly the previous value plus the extended step, or a hold, that the shift register never reaches the all-zero state, and that the flag stays set until a clear. Only the bench scenarios show the exact sequences. These are the wrap from the most negative value to a positive one, the pseudo-random run across a pause in another mode, the reload when re-entering mode 01 against a repeated mode 01 write, and the masked and unmasked interrupt with a clear that collides with a set.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RAMP = 2'b01,
    MODE_PRBS = 2'b10,
    MODE_EXT  = 2'b11
  } tsg_mode_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_BASE = 2'd1;
  localparam logic [1:0] ADDR_INC  = 2'd2;
  localparam logic [1:0] ADDR_IRQ  = 2'd3;
endpackage

// File: rtl/tsg_regs.sv
module tsg_regs
  import tsg_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             result_i,
  output tsg_mode_e        mode_o,
  output logic [REG_W-1:0] inc_o,
  output logic             load_o,
  output logic [REG_W-1:0] load_val_o,
  output logic             flag_o,
  output logic             irq_o
);
  tsg_mode_e        mode_q;
  logic [REG_W-1:0] base_q, inc_q;
  logic             mask_q, flag_q;
  logic             wr_mode, wr_base, wr_inc, wr_irq, clr, set;

  assign wr_mode = wr_en_i && wr_addr_i == ADDR_MODE;
  assign wr_base = wr_en_i && wr_addr_i == ADDR_BASE;
  assign wr_inc  = wr_en_i && wr_addr_i == ADDR_INC;
  assign wr_irq  = wr_en_i && wr_addr_i == ADDR_IRQ;
  assign clr     = wr_irq && wr_data_i[0];
  assign set     = result_i && mode_q != MODE_OFF;

  // reload on base write or on entry into ramp mode
  assign load_o     = wr_base || (wr_mode && wr_data_i[1:0] == MODE_RAMP && mode_q != MODE_RAMP);
  assign load_val_o = wr_base ? wr_data_i : base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      base_q <= '0;
      inc_q  <= '0;
      mask_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= tsg_mode_e'(wr_data_i[1:0]);
      if (wr_base) base_q <= wr_data_i;
      if (wr_inc)  inc_q  <= wr_data_i;
      if (wr_irq)  mask_q <= wr_data_i[1];
      if (set)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign inc_o  = inc_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q && mask_q;

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr) |=> flag_o);
  a_r9_off_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && mode_o == MODE_OFF) |=> !flag_o);
  a_r10_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
endmodule

// File: rtl/tsg_accum.sv
module tsg_accum #(
  parameter int ACC_W = 18,
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [REG_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic [REG_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int EXT_W = ACC_W - REG_W;

  logic [ACC_W-1:0] acc_q, load_ext, inc_ext;

  assign load_ext = {{EXT_W{load_val_i[REG_W-1]}}, load_val_i};
  assign inc_ext  = {{EXT_W{inc_i[REG_W-1]}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= load_ext;
    else if (step_i) acc_q <= acc_q + inc_ext; // wraps mod 2^ACC_W
  end

  assign acc_o = acc_q;

  a_r3_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (&acc_q[ACC_W-1:REG_W-1] || ~|acc_q[ACC_W-1:REG_W-1]));
  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> acc_q == $past(acc_q) + $past(inc_ext));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(acc_q));
endmodule

// File: rtl/tsg_lfsr.sv
module tsg_lfsr #(
  parameter int W   = 18,
  parameter int TAP = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] SEED = W'(1);

  logic [W-1:0] s_q;
  logic         fb;

  assign fb = s_q[W-1] ^ s_q[TAP-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= SEED;
    else if (step_i) s_q <= {s_q[W-2:0], fb};
  end

  assign state_o = s_q;

  a_r7_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_q != '0);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(s_q));
endmodule

// File: rtl/tsg_top.sv
module tsg_top
  import tsg_pkg::*;
#(
  parameter int ACC_W = 18,
  parameter int REG_W = 16,
  parameter int TAP   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             result_i,
  input  logic [ACC_W-1:0] ext_i_i,
  input  logic [ACC_W-1:0] ext_q_i,
  output logic [ACC_W-1:0] sig_i_o,
  output logic [ACC_W-1:0] sig_q_o,
  output logic             flag_o,
  output logic             irq_o
);
  tsg_mode_e        mode;
  logic [REG_W-1:0] inc, load_val;
  logic             load;
  logic [ACC_W-1:0] acc, acc_rev, prbs, prbs_rev;

  tsg_regs #(.REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .result_i,
    .mode_o(mode), .inc_o(inc), .load_o(load), .load_val_o(load_val),
    .flag_o, .irq_o
  );

  tsg_accum #(.ACC_W(ACC_W), .REG_W(REG_W)) u_accum (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val),
    .step_i(mode == MODE_RAMP), .inc_i(inc), .acc_o(acc)
  );

  tsg_lfsr #(.W(ACC_W), .TAP(TAP)) u_lfsr (
    .clk_i, .rst_ni, .step_i(mode == MODE_PRBS), .state_o(prbs)
  );

  for (genvar k = 0; k < ACC_W; k++) begin : g_rev
    assign acc_rev[k]  = acc[ACC_W-1-k];
    assign prbs_rev[k] = prbs[ACC_W-1-k];
  end

  always_comb begin
    unique case (mode)
      MODE_RAMP: begin sig_i_o = acc;     sig_q_o = acc_rev;  end
      MODE_PRBS: begin sig_i_o = prbs;    sig_q_o = prbs_rev; end
      MODE_EXT:  begin sig_i_o = ext_i_i; sig_q_o = ext_q_i;  end
      default:   begin sig_i_o = '0;      sig_q_o = '0;       end
    endcase
  end

  a_r2_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_OFF |-> (sig_i_o == '0 && sig_q_o == '0));
  a_r8_ext_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_EXT |-> (sig_i_o == ext_i_i && sig_q_o == ext_q_i));

  for (genvar k = 0; k < ACC_W; k++) begin : g_chk_rev
    a_r6_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == MODE_RAMP || mode == MODE_PRBS) |-> sig_q_o[k] == sig_i_o[ACC_W-1-k]);
  end
endmodule

// File: tb/sim_tsg_top.sv
module sim_tsg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        result = 1'b0;
  logic [17:0] ext_i = '0, ext_q = '0;
  logic [17:0] sig_i, sig_q;
  logic        flag, irq;

  always #10 clk = ~clk; // 50 MHz

  tsg_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .result_i(result), .ext_i_i(ext_i), .ext_q_i(ext_q),
    .sig_i_o(sig_i), .sig_q_o(sig_q), .flag_o(flag), .irq_o(irq)
  );

  typedef struct packed {
    logic [17:0] i;
    logic [17:0] q;
    logic        flag;
    logic        irq;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;

  // reference state
  logic [1:0]  m_mode = 0;
  logic [15:0] m_base = 0, m_inc = 0;
  logic        m_mask = 0, m_flag = 0;
  logic [17:0] m_acc = 0, m_lfsr = 18'h1;

  function automatic logic [17:0] mirror(input logic [17:0] v);
    logic [17:0] r;
    for (int k = 0; k < 18; k++) r[k] = v[17-k];
    return r;
  endfunction

  function automatic logic [17:0] sx(input logic [15:0] v);
    return {{2{v[15]}}, v};
  endfunction

  task automatic cyc(input bit we, input logic [1:0] a, input logic [15:0] d,
                     input bit res, input logic [17:0] ei, input logic [17:0] eq,
                     input string tag);
    bit   ld, set, clr;
    exp_t e;
    @(negedge clk); #1;
    wr_en = we; wr_addr = a; wr_data = d; result = res; ext_i = ei; ext_q = eq;
    @(posedge clk);
    ld  = we && (a == 2'd1 || (a == 2'd0 && d[1:0] == 2'b01 && m_mode != 2'b01));
    set = res && m_mode != 2'b00;
    clr = we && a == 2'd3 && d[0];
    if (ld) m_acc = sx(a == 2'd1 ? d : m_base);
    else if (m_mode == 2'b01) m_acc = m_acc + sx(m_inc);
    if (m_mode == 2'b10) m_lfsr = {m_lfsr[16:0], m_lfsr[17] ^ m_lfsr[10]};
    if (set) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    if (we) begin
      case (a)
        2'd0: m_mode = d[1:0];
        2'd1: m_base = d;
        2'd2: m_inc  = d;
        default: m_mask = d[1];
      endcase
    end
    case (m_mode)
      2'b01: begin e.i = m_acc;  e.q = mirror(m_acc);  end
      2'b10: begin e.i = m_lfsr; e.q = mirror(m_lfsr); end
      2'b11: begin e.i = ei;     e.q = eq;             end
      default: begin e.i = '0;   e.q = '0;             end
    endcase
    e.flag = m_flag;
    e.irq  = m_flag && m_mask;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tag);
    cyc(1'b1, a, d, 1'b0, 18'h0, 18'h0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(1'b0, 2'd0, 16'h0, 1'b0, 18'h0, 18'h0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (sig_i !== e.i || sig_q !== e.q || flag !== e.flag || irq !== e.irq) begin
          n_fail++;
          $display("FAIL %s: i=%h q=%h flag=%b irq=%b expected i=%h q=%h flag=%b irq=%b",
                   t, sig_i, sig_q, flag, irq, e.i, e.q, e.flag, e.irq);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (sig_i !== 0 || sig_q !== 0 || flag !== 0 || irq !== 0) begin
      n_fail++;
      $display("FAIL R1: i=%h q=%h flag=%b irq=%b expected all zero", sig_i, sig_q, flag, irq);
    end
    @(negedge clk); rst_n = 1'b1;

    idle(2, "R1");
    // R2 / R9: off mode ignores external inputs and result pulses
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 18'h2AAAA, 18'h15555, "R2");
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 18'h3FFFF, 18'h00001, "R9");

    // R3: negative base, DC level
    wr(2'd1, 16'h8001, "R3");
    wr(2'd0, 16'h0001, "R3");
    idle(3, "R4");
    // R4: sawtooth
    wr(2'd2, 16'h0003, "R4");
    idle(4, "R4");
    wr(2'd2, 16'hFFFE, "R4");
    idle(3, "R4");
    // R11: repeated mode 01 write keeps running
    wr(2'd0, 16'h0001, "R11");
    idle(2, "R11");
    // R5: wrap from the most negative range
    wr(2'd1, 16'h8000, "R3");
    wr(2'd2, 16'h8000, "R5");
    idle(5, "R5");
    // positive wrap
    wr(2'd1, 16'h7FFF, "R3");
    wr(2'd2, 16'h7FFF, "R5");
    idle(6, "R5");

    // R7 / R6: pseudo-random
    wr(2'd0, 16'h0002, "R7");
    idle(40, "R7");
    wr(2'd0, 16'h0000, "R7");
    idle(3, "R7");
    wr(2'd0, 16'h0002, "R6");
    idle(10, "R6");

    // R8: external
    wr(2'd0, 16'h0003, "R8");
    cyc(1'b0, 2'd0, 16'h0, 1'b0, 18'h12345, 18'h2ABCD, "R8");
    cyc(1'b0, 2'd0, 16'h0, 1'b0, 18'h3FFFF, 18'h00000, "R8");
    cyc(1'b0, 2'd0, 16'h0, 1'b0, 18'h00001, 18'h20000, "R8");

    // R9 / R10: interrupt flag
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 18'h0, 18'h0, "R9");
    idle(2, "R10");
    wr(2'd3, 16'h0002, "R10");
    idle(1, "R10");
    cyc(1'b1, 2'd3, 16'h0003, 1'b1, 18'h0, 18'h0, "R9");
    wr(2'd3, 16'h0003, "R9");
    idle(1, "R9");
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 18'h0, 18'h0, "R10");
    wr(2'd3, 16'h0000, "R10");
    wr(2'd3, 16'h0001, "R9");

    // R3: re-entry into ramp mode reloads the stored base
    wr(2'd0, 16'h0001, "R3");
    idle(3, "R4");

    idle(2, "R1");
    done = 1'b1;
    finish_run();
  end
endmodule